// File: doc/BRIEF.md
# Edge-Latched Interrupt Status Controller

This block gathers six level signals (for example individual parallel-port lines or a counter output) into a sticky status register and drives a single interrupt line toward the host. Each source passes through a two-flop synchronizer. A rising edge on the synchronized value sets the matching status bit, but only while that source is enabled. The interrupt line is high whenever the status register holds any set bit. It therefore rises when the register leaves all-zero and stays high until the register is all-zero again.

The host sees two registers through a small register port. It writes the source-enable register, and it reads either the status register or the enable register. There is no clear register. Software acknowledges a source by writing a zero to its enable bit, which also clears its status bit. Writing a one to that bit arms the source again. Reads have no strobe and change nothing.

Top module: `edge_irq_latch`

## Requirements
- R1: A synchronized 0-to-1 transition on an enabled source sets its status bit. With the source changed just after a clock edge, the bit is still 0 after the second following rising edge and is 1 after the third.
- R2: A rising source whose enable bit is 0 leaves its status bit at 0.
- R3: Writing 0 to an enable bit clears the matching status bit at the clock edge of the write. Nothing else clears a status bit apart from reset.
- R4: Setting an enable bit while its source is already high does not set the status bit. Only a later fresh rising edge does.
- R5: `irqOut` is 1 exactly when some status bit is 1. It rises only from an all-zero status and falls only when every status bit is 0.
- R6: After reset, the enable register, the status register and `irqOut` are all 0.
- R7: With `regRdSel`=0, `regRdData[5:0]` returns status bit n in bit n. With `regRdSel`=1 it returns the enable register, where bit n enables source `srcIn[n]`. `regRdData[7:6]` always read 0, and bits 7:6 of a write are discarded.
- R8: A set status bit stays set while its enable bit stays 1, even after its source falls back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWrEn | input | 1 | Writes `regWrData` into the enable register this cycle |
| regWrData | input | 8 | Write data; bits 5:0 are the per-source enables |
| regRdSel | input | 1 | Read select: 0 = status, 1 = enable |
| regRdData | output | 8 | Selected register, zero-extended |
| srcIn | input | 6 | Asynchronous interrupt source levels |
| irqOut | output | 1 | Interrupt request to the host |

## Verification
The bench measures the exact synchronizer latency. A design with one stage too few or too many sets the bit one edge early or late. It re-enables a source whose level is already high. A design that latches levels instead of edges would then raise a spurious bit. It clears one bit of several to confirm that the interrupt holds while any bit remains. A design that drops the line on a partial clear, or that fails to clear the status bit along with the enable bit, is caught here. It writes ones into the unused upper bits and resets in the middle of activity, to catch leaking upper bits and state that survives reset.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // Strobes the control half hands to the datapath each cycle.
  typedef struct packed {
    logic enLoad;    // enable register is being written this cycle
    logic rdEnable;  // read port selects the enable register
  } irqStrobe_t;

  typedef enum logic {
    SEL_STATUS = 1'b0,
    SEL_ENABLE = 1'b1
  } rdSel_e;

endpackage

// File: rtl/irq_src_sync.sv
module irq_src_sync #(
  parameter int NUM_SRC = 6,
  parameter int STAGES  = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_SRC-1:0] srcAsync,
  output logic [NUM_SRC-1:0] srcSync
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) chain <= '0;
      else       chain <= {chain[STAGES-2:0], srcAsync[g]};
    end
    assign srcSync[g] = chain[STAGES-1];
  end

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               regRdSel,
  output irqStrobe_t         strobe,
  output logic [NUM_SRC-1:0] enQ,
  output logic [NUM_SRC-1:0] enNext
);

  always_comb begin
    strobe.enLoad   = regWrEn;
    strobe.rdEnable = (rdSel_e'(regRdSel) == SEL_ENABLE);
  end

  // Upper write bits are discarded.
  if (DATA_W > NUM_SRC) begin : g_hi
    logic unusedWrHi;
    assign unusedWrHi = ^regWrData[DATA_W-1:NUM_SRC];
  end

  assign enNext = strobe.enLoad ? regWrData[NUM_SRC-1:0] : enQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) enQ <= '0;
    else       enQ <= enNext;
  end

  // R7: enable register only changes on a write
  p_en_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    !regWrEn |=> $stable(enQ));

  // R3: a write lands exactly in the enable register
  p_en_load_r3: assert property (@(posedge clk) disable iff (!rstN)
    regWrEn |=> (enQ == $past(regWrData[NUM_SRC-1:0])));

endmodule

// File: rtl/irq_datapath.sv
module irq_datapath
  import irq_pkg::*;
#(
  parameter int NUM_SRC = 6,
  parameter int DATA_W  = 8
) (
  input  logic               clk,
  input  logic               rstN,
  input  irqStrobe_t         strobe,
  input  logic [NUM_SRC-1:0] enQ,
  input  logic [NUM_SRC-1:0] enNext,
  input  logic [NUM_SRC-1:0] srcSync,
  output logic [DATA_W-1:0]  rdData,
  output logic               irqQ
);

  logic [NUM_SRC-1:0] srcPrev;
  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC-1:0] statusQ;
  logic [NUM_SRC-1:0] statusNext;

  // Edge detector on the synchronized level, running whatever the enables.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcPrev <= '0;
    else       srcPrev <= srcSync;
  end

  assign rise = srcSync & ~srcPrev;

  // Set only through an enabled edge; cleared by the enable that takes effect.
  assign statusNext = (statusQ | (rise & enQ)) & enNext;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      statusQ <= '0;
      irqQ    <= 1'b0;
    end else begin
      statusQ <= statusNext;
      irqQ    <= |statusNext;
    end
  end

  always_comb begin
    rdData = '0;
    rdData[NUM_SRC-1:0] = strobe.rdEnable ? enQ : statusQ;
  end

  // R3: no status bit survives without its enable
  p_status_masked_r3: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~enQ) == '0);

  // R2: a newly set bit had its enable set in the previous cycle
  p_set_needs_en_r2: assert property (@(posedge clk) disable iff (!rstN)
    (statusQ & ~$past(statusQ) & ~$past(enQ)) == '0);

  // R8: a set bit whose enable stayed on is still set
  p_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    ($past(statusQ) & $past(enQ) & enQ & ~statusQ) == '0);

  // R5: line rises only from an empty register
  p_irq_rise_r5: assert property (@(posedge clk) disable iff (!rstN)
    $rose(irqQ) |-> ($past(statusQ) == '0));

  // R5: line falls only when the register is empty
  p_irq_fall_r5: assert property (@(posedge clk) disable iff (!rstN)
    $fell(irqQ) |-> (statusQ == '0));

  // R5: line tracks the register content
  p_irq_level_r5: assert property (@(posedge clk) disable iff (!rstN)
    irqQ == (statusQ != '0));

endmodule

// File: rtl/edge_irq_latch.sv
module edge_irq_latch
  import irq_pkg::*;
#(
  parameter int NUM_SRC     = 6,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [DATA_W-1:0]  regWrData,
  input  logic               regRdSel,
  output logic [DATA_W-1:0]  regRdData,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut
);

  irqStrobe_t         strobe;
  logic [NUM_SRC-1:0] enQ;
  logic [NUM_SRC-1:0] enNext;
  logic [NUM_SRC-1:0] srcSync;

  irq_src_sync #(.NUM_SRC(NUM_SRC), .STAGES(SYNC_STAGES)) uSync (
    .clk(clk), .rstN(rstN), .srcAsync(srcIn), .srcSync(srcSync)
  );

  irq_ctrl #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uCtrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdSel(regRdSel), .strobe(strobe), .enQ(enQ), .enNext(enNext)
  );

  irq_datapath #(.NUM_SRC(NUM_SRC), .DATA_W(DATA_W)) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe), .enQ(enQ), .enNext(enNext),
    .srcSync(srcSync), .rdData(regRdData), .irqQ(irqOut)
  );

  // R7: bits above the sources never read as one
  p_upper_zero_r7: assert property (@(posedge clk) disable iff (!rstN)
    regRdData[DATA_W-1:NUM_SRC] == '0);

endmodule

// File: tb/tb_edge_irq_latch.sv
module tb_edge_irq_latch;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       regWrEn = 1'b0;
  logic [7:0] regWrData = '0;
  logic       regRdSel = 1'b0;
  logic [7:0] regRdData;
  logic [5:0] srcIn = '0;
  logic       irqOut;

  int total = 0;
  int bad = 0;

  always #2 clk = ~clk;

  edge_irq_latch dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .regRdSel(regRdSel), .regRdData(regRdData), .srcIn(srcIn), .irqOut(irqOut)
  );

  // {enable[7:0], src[5:0], expected status[5:0]}; irq expected = status != 0
  localparam int NV = 15;
  localparam logic [19:0] VEC [NV] = '{
    {8'h00, 6'h00, 6'h00},  // R6 idle
    {8'h3F, 6'h01, 6'h01},  // R1 first edge
    {8'h3F, 6'h03, 6'h03},  // R1 second edge accumulates
    {8'h3E, 6'h03, 6'h02},  // R3 partial clear, R5 line holds
    {8'h3E, 6'h00, 6'h02},  // R8 sticky after source falls
    {8'h3F, 6'h00, 6'h02},  // re-arm, no edge
    {8'h3F, 6'h21, 6'h23},  // R1 more edges
    {8'h00, 6'h21, 6'h00},  // R3 full clear, R5 line drops
    {8'h21, 6'h21, 6'h00},  // R4 re-enable with level high
    {8'h21, 6'h00, 6'h00},
    {8'h21, 6'h3F, 6'h21},  // R2 disabled bits ignore edges
    {8'h01, 6'h3F, 6'h01},  // R3
    {8'h00, 6'h00, 6'h00},
    {8'h10, 6'h00, 6'h00},
    {8'h10, 6'h10, 6'h10}   // R1
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%h exp=%h", req, got, exp);
    end
  endtask

  task automatic writeEn(input logic [7:0] d);
    @(negedge clk);
    regWrEn   = 1'b1;
    regWrData = d;
    @(negedge clk);
    regWrEn   = 1'b0;
  endtask

  task automatic readReg(input logic sel, output logic [7:0] val);
    regRdSel = sel;
    #1;
    val = regRdData;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    bad++;
    total++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : main
    logic [7:0] rd;
    logic [5:0] expSt;

    repeat (3) @(negedge clk);
    // R6: reset state
    readReg(1'b0, rd); check("R6 status", rd, 8'h00);
    readReg(1'b1, rd); check("R6 enable", rd, 8'h00);
    check("R6 irq", {7'd0, irqOut}, 8'h00);
    rstN = 1'b1;
    @(negedge clk);
    check("R6 irq after release", {7'd0, irqOut}, 8'h00);

    // table walk
    for (int i = 0; i < NV; i++) begin
      writeEn(VEC[i][19:12]);
      srcIn = VEC[i][11:6];
      repeat (5) @(negedge clk);
      expSt = VEC[i][5:0];
      readReg(1'b0, rd);
      check($sformatf("R1/R3/R4 vec %0d status", i), rd, {2'b00, expSt});
      check($sformatf("R5 vec %0d irq", i), {7'd0, irqOut}, {7'd0, expSt != 6'h00});
    end

    // R7: upper write bits discarded, upper read bits zero
    writeEn(8'hFF);
    readReg(1'b1, rd); check("R7 enable readback", rd, 8'h3F);
    srcIn = 6'h00;
    repeat (4) @(negedge clk);
    readReg(1'b0, rd); check("R7 status upper zero", rd, 8'h10);

    // R1: exact latency; src changes right after an edge
    writeEn(8'h3F);
    srcIn = 6'h04;
    @(negedge clk); @(negedge clk);
    readReg(1'b0, rd); check("R1 not yet after two edges", rd, 8'h10);
    @(negedge clk);
    readReg(1'b0, rd); check("R1 set after third edge", rd, 8'h14);
    // R7: reading has no effect
    readReg(1'b1, rd); readReg(1'b0, rd);
    check("R7 read no side effect", rd, 8'h14);

    // R2: edge while disabled, then enable: stays zero
    writeEn(8'h00);
    srcIn = 6'h00;
    repeat (4) @(negedge clk);
    srcIn = 6'h08;
    repeat (5) @(negedge clk);
    writeEn(8'h08);
    repeat (3) @(negedge clk);
    readReg(1'b0, rd); check("R2 disabled edge ignored", rd, 8'h00);
    check("R2 irq low", {7'd0, irqOut}, 8'h00);

    // R6: reset mid-activity
    srcIn = 6'h00;
    repeat (4) @(negedge clk);
    srcIn = 6'h08;
    repeat (5) @(negedge clk);
    check("R6 pre-reset irq", {7'd0, irqOut}, 8'h01);
    rstN = 1'b0;
    @(negedge clk);
    readReg(1'b0, rd); check("R6 status cleared", rd, 8'h00);
    readReg(1'b1, rd); check("R6 enable cleared", rd, 8'h00);
    check("R6 irq cleared", {7'd0, irqOut}, 8'h00);
    rstN = 1'b1;
    repeat (2) @(negedge clk);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule